// File: doc/BRIEF.md
# Reference PLL Power-Up and Lock Sequencer

This block brings a serdes reference PLL from power-off to a locked, usable clock. After a start pulse it switches on the PLL supply and its regulator together, lifts the isolation clamp, then sets the termination, buffer and reference-select controls. It then releases the PLL reset and polls the lock indication once per millisecond. The post-divider reset is released only after lock has been seen. Each of the first three steps is followed by a fixed settling gap. All time is measured by a prescaler that turns clock cycles into microseconds.

When the bypass input is high at the start pulse, none of this happens. A ready bit supplied from outside decides the outcome, and the controls keep their present values. The result of a run is shown on two status flags. `busy` covers the time the sequence is running.

Timing symbols used below: D = SETTLE_US*CLKS_PER_US cycles and M = US_PER_MS*CLKS_PER_US cycles.

Top module: `refpll_bringup_seq`

## Requirements
- R1: After reset the outputs are as follows: `pll_pwr_en`=0, `ldo_en`=0, `iso_hold`=1, `term_ctrl`=0, `buf_ctrl`=0, `ref_sel_pad`=1, `pll_rst_n`=0, `post_rst_n`=0, `busy`=0, `lock_ok`=0, `bringup_err`=0.
- R2: A start while idle with `bypass` low sets `pll_pwr_en`, `ldo_en` and `busy` together on the clock edge that samples the start.
- R3: `iso_hold` falls exactly D cycles after power is applied.
- R4: Exactly D cycles after isolation is removed, on one edge, `term_ctrl` becomes 0xE0, `buf_ctrl` becomes 0x1A and `ref_sel_pad` becomes 0 (0 selects the differential mux output).
- R5: `pll_rst_n` rises exactly D cycles after the R4 edge.
- R6: `pll_lock` is sampled at the first edge after the reset release and then every M cycles, LOCK_TRIES samples in all. The first sample that sees lock sets `post_rst_n` and `lock_ok` and clears `busy` on that edge. `post_rst_n` never rises without lock.
- R7: If none of the samples sees lock, `bringup_err` rises and `busy` falls LOCK_TRIES*M+1 cycles after the reset release. `post_rst_n` stays 0 and `pll_rst_n` stays 1.
- R8: A start while idle with `bypass` high sets `lock_ok`=`bypass_ready` and `bringup_err`=!`bypass_ready` on the next edge. `busy` stays 0 and every control output keeps its value.
- R9: A start while `busy` is high has no effect.
- R10: A new non-bypass start from idle clears both status flags and returns all controls to their reset values, except power and regulator, which are set. It then repeats the timing of R3 to R7.
- R11: Lock that is high only between sampling edges is not acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| bypass | input | 1 | Skip the power-up; result taken from `bypass_ready` |
| bypass_ready | input | 1 | Externally provided ready bit used in bypass |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_pwr_en | output | 1 | PLL power enable |
| ldo_en | output | 1 | PLL regulator enable |
| iso_hold | output | 1 | Isolation clamp, 1 = isolated |
| term_ctrl | output | 8 | Termination control field |
| buf_ctrl | output | 8 | Buffer and converter enable field |
| ref_sel_pad | output | 1 | Reference select, 0 = differential mux output |
| pll_rst_n | output | 1 | PLL reset, active low |
| post_rst_n | output | 1 | Post-divider reset, active low |
| busy | output | 1 | Sequence running |
| lock_ok | output | 1 | Last run succeeded |
| bringup_err | output | 1 | Last run failed |

## Verification
The assertions assume that `pll_lock`, `start`, `bypass` and `bypass_ready` are synchronous to `clk`. They also assume that `bypass_ready` is valid in the same cycle as the start it qualifies. The bench drives every input on the falling edge, so each input is stable across the sampling edge.

A behavioural model counts cycles from the accepted start and derives every output from elapsed time and the sampled lock. The stimulus places lock changes on a sampling edge, between sampling edges, on the last sample, and never.

// File: rtl/refpll_seq_pkg.sv
package refpll_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_UNISO,
    ST_CONFIG,
    ST_FIRST,
    ST_POLL
  } seq_state_t;

  localparam logic [7:0] TERM_DISCONNECT = 8'hE0;
  localparam logic [7:0] BUF_ENABLE      = 8'h1A;

endpackage

// File: rtl/refpll_delay_timer.sv
module refpll_delay_timer #(
  parameter int CLKS_PER_US = 100,
  parameter int MAX_US      = 1000,
  localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1,
  localparam int UW = $clog2(MAX_US + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [UW-1:0] load_us,
  output logic          expire
);

  logic          running;
  logic [PW-1:0] pre;
  logic [UW-1:0] us_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pre     <= '0;
      us_left <= '0;
    end else if (load) begin
      running <= 1'b1;
      pre     <= PW'(CLKS_PER_US - 1);
      us_left <= load_us - UW'(1);
    end else if (running) begin
      if (pre == '0) begin
        pre <= PW'(CLKS_PER_US - 1);
        if (us_left == '0) running <= 1'b0;
        else               us_left <= us_left - UW'(1);
      end else begin
        pre <= pre - PW'(1);
      end
    end
  end

  assign expire = running && (pre == '0) && (us_left == '0);

  // R3
  run_from_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(load));

endmodule

// File: rtl/refpll_try_counter.sv
module refpll_try_counter #(
  parameter int TRIES = 5,
  localparam int TW = $clog2(TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last
);

  logic [TW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (clear) count <= TW'(1);
    else if (bump)  count <= count + TW'(1);
  end

  assign last = (count == TW'(TRIES));

  // R7
  try_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= TW'(TRIES));

endmodule

// File: rtl/refpll_bringup_seq.sv
module refpll_bringup_seq
  import refpll_seq_pkg::*;
#(
  parameter int CLKS_PER_US = 100,
  parameter int SETTLE_US   = 500,
  parameter int US_PER_MS   = 1000,
  parameter int LOCK_TRIES  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       bypass,
  input  logic       bypass_ready,
  input  logic       pll_lock,
  output logic       pll_pwr_en,
  output logic       ldo_en,
  output logic       iso_hold,
  output logic [7:0] term_ctrl,
  output logic [7:0] buf_ctrl,
  output logic       ref_sel_pad,
  output logic       pll_rst_n,
  output logic       post_rst_n,
  output logic       busy,
  output logic       lock_ok,
  output logic       bringup_err
);

  localparam int MAX_US = (SETTLE_US > US_PER_MS) ? SETTLE_US : US_PER_MS;
  localparam int UW     = $clog2(MAX_US + 1);

  seq_state_t    state;
  logic          tmr_load, tmr_expire;
  logic [UW-1:0] tmr_us;
  logic          try_clear, try_bump, try_last;
  logic          polling;

  assign polling = (state == ST_FIRST) || (state == ST_POLL);
  assign tmr_us  = polling ? UW'(US_PER_MS) : UW'(SETTLE_US);

  always_comb begin
    tmr_load  = 1'b0;
    try_clear = 1'b0;
    try_bump  = 1'b0;
    case (state)
      ST_IDLE:  tmr_load = start && !bypass;
      ST_POWER,
      ST_UNISO: tmr_load = tmr_expire;
      ST_FIRST: begin
        tmr_load  = !pll_lock;
        try_clear = !pll_lock;
      end
      ST_POLL: begin
        tmr_load = tmr_expire && !try_last && !pll_lock;
        try_bump = tmr_expire && !try_last && !pll_lock;
      end
      default: ;
    endcase
  end

  refpll_delay_timer #(.CLKS_PER_US(CLKS_PER_US), .MAX_US(MAX_US)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_us(tmr_us), .expire(tmr_expire)
  );

  refpll_try_counter #(.TRIES(LOCK_TRIES)) u_tries (
    .clk(clk), .rst(rst), .clear(try_clear), .bump(try_bump), .last(try_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pll_pwr_en  <= 1'b0;
      ldo_en      <= 1'b0;
      iso_hold    <= 1'b1;
      term_ctrl   <= '0;
      buf_ctrl    <= '0;
      ref_sel_pad <= 1'b1;
      pll_rst_n   <= 1'b0;
      post_rst_n  <= 1'b0;
      busy        <= 1'b0;
      lock_ok     <= 1'b0;
      bringup_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          if (bypass) begin
            lock_ok     <= bypass_ready;
            bringup_err <= !bypass_ready;
          end else begin
            pll_pwr_en  <= 1'b1;
            ldo_en      <= 1'b1;
            iso_hold    <= 1'b1;
            term_ctrl   <= '0;
            buf_ctrl    <= '0;
            ref_sel_pad <= 1'b1;
            pll_rst_n   <= 1'b0;
            post_rst_n  <= 1'b0;
            busy        <= 1'b1;
            lock_ok     <= 1'b0;
            bringup_err <= 1'b0;
            state       <= ST_POWER;
          end
        end
        ST_POWER: if (tmr_expire) begin
          iso_hold <= 1'b0;
          state    <= ST_UNISO;
        end
        ST_UNISO: if (tmr_expire) begin
          term_ctrl   <= TERM_DISCONNECT;
          buf_ctrl    <= BUF_ENABLE;
          ref_sel_pad <= 1'b0;
          state       <= ST_CONFIG;
        end
        ST_CONFIG: if (tmr_expire) begin
          pll_rst_n <= 1'b1;
          state     <= ST_FIRST;
        end
        ST_FIRST: begin
          if (pll_lock) begin
            post_rst_n <= 1'b1;
            lock_ok    <= 1'b1;
            busy       <= 1'b0;
            state      <= ST_IDLE;
          end else begin
            state <= ST_POLL;
          end
        end
        ST_POLL: if (tmr_expire) begin
          if (try_last) begin
            bringup_err <= 1'b1;
            busy        <= 1'b0;
            state       <= ST_IDLE;
          end else if (pll_lock) begin
            post_rst_n <= 1'b1;
            lock_ok    <= 1'b1;
            busy       <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  post_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(post_rst_n) |-> ($past(pll_lock) && pll_rst_n));

  // R5
  cfg_before_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_rst_n) |-> (term_ctrl == TERM_DISCONNECT && buf_ctrl == BUF_ENABLE && !ref_sel_pad));

  // R3
  iso_after_power_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_hold) |-> (pll_pwr_en && ldo_en));

  // R7
  status_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lock_ok && bringup_err));

  // R9
  busy_no_status_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!lock_ok && !bringup_err));

  // R8
  bypass_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && bypass) |=> ($stable(pll_rst_n) && $stable(post_rst_n) && $stable(pll_pwr_en) && !busy));

endmodule

// File: tb/refpll_bringup_seq_test.sv
module refpll_bringup_seq_test;

  localparam int C     = 2;
  localparam int SU    = 3;
  localparam int UPM   = 4;
  localparam int TRIES = 5;
  localparam int D     = SU * C;
  localparam int M     = UPM * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, bypass = 1'b0, bypass_ready = 1'b0, pll_lock = 1'b0;
  logic pll_pwr_en, ldo_en, iso_hold, ref_sel_pad, pll_rst_n, post_rst_n;
  logic busy, lock_ok, bringup_err;
  logic [7:0] term_ctrl, buf_ctrl;

  always #10 clk = ~clk;

  refpll_bringup_seq #(.CLKS_PER_US(C), .SETTLE_US(SU), .US_PER_MS(UPM), .LOCK_TRIES(TRIES)) uut (
    .clk(clk), .rst(rst), .start(start), .bypass(bypass), .bypass_ready(bypass_ready),
    .pll_lock(pll_lock), .pll_pwr_en(pll_pwr_en), .ldo_en(ldo_en), .iso_hold(iso_hold),
    .term_ctrl(term_ctrl), .buf_ctrl(buf_ctrl), .ref_sel_pad(ref_sel_pad),
    .pll_rst_n(pll_rst_n), .post_rst_n(post_rst_n), .busy(busy), .lock_ok(lock_ok),
    .bringup_err(bringup_err)
  );

  int vectors = 0;
  int miscompares = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;
  string scen = "R1 reset";

  // behavioural reference model
  logic e_pwr, e_ldo, e_iso, e_ref, e_prst, e_post, e_busy, e_ok, e_err;
  logic [7:0] e_term, e_buf;
  bit m_busy;
  int mt;

  always @(posedge clk) begin
    if (rst) begin
      e_pwr = 0; e_ldo = 0; e_iso = 1; e_term = 0; e_buf = 0; e_ref = 1;
      e_prst = 0; e_post = 0; e_busy = 0; e_ok = 0; e_err = 0;
      m_busy = 0; mt = 0;
    end else if (!m_busy) begin
      if (start) begin
        if (bypass) begin
          e_ok = bypass_ready; e_err = !bypass_ready;
        end else begin
          e_pwr = 1; e_ldo = 1; e_iso = 1; e_term = 0; e_buf = 0; e_ref = 1;
          e_prst = 0; e_post = 0; e_busy = 1; e_ok = 0; e_err = 0;
          m_busy = 1; mt = 0;
        end
      end
    end else begin
      mt++;
      if (mt == D) e_iso = 0;
      if (mt == 2*D) begin e_term = 8'hE0; e_buf = 8'h1A; e_ref = 0; end
      if (mt == 3*D) e_prst = 1;
      if (mt > 3*D) begin
        int k;
        k = mt - 3*D - 1;
        if (k == TRIES*M) begin
          e_err = 1; e_busy = 0; m_busy = 0;
        end else if ((k % M == 0) && pll_lock) begin
          e_post = 1; e_ok = 1; e_busy = 0; m_busy = 0;
        end
      end
    end
  end

  task automatic cmp(string tag, string sig, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", tag, scen, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !finished) begin
      vectors++;
      cmp("R2", "pll_pwr_en", {7'd0, pll_pwr_en}, {7'd0, e_pwr});
      cmp("R2", "ldo_en", {7'd0, ldo_en}, {7'd0, e_ldo});
      cmp("R3", "iso_hold", {7'd0, iso_hold}, {7'd0, e_iso});
      cmp("R4", "term_ctrl", term_ctrl, e_term);
      cmp("R4", "buf_ctrl", buf_ctrl, e_buf);
      cmp("R4", "ref_sel_pad", {7'd0, ref_sel_pad}, {7'd0, e_ref});
      cmp("R5", "pll_rst_n", {7'd0, pll_rst_n}, {7'd0, e_prst});
      cmp("R6", "post_rst_n", {7'd0, post_rst_n}, {7'd0, e_post});
      cmp("R6", "lock_ok", {7'd0, lock_ok}, {7'd0, e_ok});
      cmp("R7", "bringup_err", {7'd0, bringup_err}, {7'd0, e_err});
      cmp("R9", "busy", {7'd0, busy}, {7'd0, e_busy});
    end
  end

  task automatic expect_bit(string tag, string sig, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, sig, act, exp);
    end
  endtask

  task automatic pulse_start(logic byp, logic rdy);
    @(negedge clk);
    start = 1; bypass = byp; bypass_ready = rdy;
    @(negedge clk);
    start = 0; bypass = 0; bypass_ready = 0;
  endtask

  task automatic wait_release();
    while (pll_rst_n !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy !== 1'b0) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired in scenario %s", scen);
      summary();
    end
  end

  initial begin
    @(posedge clk);
    chk_en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset values
    expect_bit("R1", "iso_hold", iso_hold, 1'b1);
    expect_bit("R1", "ref_sel_pad", ref_sel_pad, 1'b1);
    expect_bit("R1", "pll_rst_n", pll_rst_n, 1'b0);
    expect_bit("R1", "busy", busy, 1'b0);

    // R6: lock present from the first sample
    scen = "R6 early lock";
    pll_lock = 1;
    pulse_start(0, 0);
    expect_bit("R2", "pll_pwr_en", pll_pwr_en, 1'b1);
    wait_idle();
    expect_bit("R6", "lock_ok", lock_ok, 1'b1);

    // R10 restart, R11 lock between samples, R9 start while busy, R7 timeout
    scen = "R11 glitch then R7 timeout";
    pll_lock = 0;
    pulse_start(0, 0);
    expect_bit("R10", "post_rst_n", post_rst_n, 1'b0);
    expect_bit("R10", "lock_ok", lock_ok, 1'b0);
    expect_bit("R10", "iso_hold", iso_hold, 1'b1);
    wait_release();
    repeat (4) @(negedge clk);
    pll_lock = 1;
    @(negedge clk);
    pll_lock = 0;
    expect_bit("R11", "post_rst_n", post_rst_n, 1'b0);
    expect_bit("R11", "busy", busy, 1'b1);
    pulse_start(1, 1);
    expect_bit("R9", "lock_ok", lock_ok, 1'b0);
    wait_idle();
    expect_bit("R7", "bringup_err", bringup_err, 1'b1);
    expect_bit("R7", "post_rst_n", post_rst_n, 1'b0);

    // R6: lock arriving on the last sample
    scen = "R6 last sample";
    pulse_start(0, 0);
    expect_bit("R10", "bringup_err", bringup_err, 1'b0);
    wait_release();
    repeat (4*M) @(negedge clk);
    pll_lock = 1;
    wait_idle();
    expect_bit("R6", "lock_ok", lock_ok, 1'b1);
    expect_bit("R6", "post_rst_n", post_rst_n, 1'b1);

    // R8 bypass, ready and not ready
    scen = "R8 bypass";
    pll_lock = 0;
    pulse_start(1, 1);
    expect_bit("R8", "lock_ok", lock_ok, 1'b1);
    expect_bit("R8", "busy", busy, 1'b0);
    pulse_start(1, 0);
    expect_bit("R8", "bringup_err", bringup_err, 1'b1);
    expect_bit("R8", "post_rst_n", post_rst_n, 1'b1);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule